// File: doc/BRIEF.md
# Prescaled One-Shot Countdown Timer

This block is a 32-bit one-shot countdown timer clocked by the core clock. Each count step lasts a programmable number of core cycles: a fixed divide-by-16 stage in series with a power-of-two divider. A three-bit code selects the power of two. Software sets the timer up through a small synchronous register port. It writes a divide code, then writes a starting count. After that it can poll the remaining count, or wait for the one-cycle expiry pulse that fires when the count reaches zero.

The register port has four addresses. Writes are single-cycle strobes with no back-pressure: a write presented with `wr_en` high is taken at the next rising clock edge. Reads are combinational from `rd_addr` to `rd_data`. There is no data stream, so the port has no valid/ready handshake. The expiry output is a plain status pin.

Top module: `tick_countdown_timer`

## Requirements
- R1: The divide register at address 0 keeps only data bits 3, 1 and 0. A read of address 0 returns those bits in place, and every other bit reads back as zero.
- R2: Form a code with bit 3 as its most significant bit and bits 1:0 below it. The step period is then 16 × 2^((code + 1) mod 8) core cycles. Code 7 gives 16 cycles, code 0 gives 32 cycles and code 6 gives 2048 cycles.
- R3: A write to address 1 stores the full 32-bit starting count, which reads back at address 1. The same write loads the current count and starts the countdown with a fresh prescaler phase. For a start value N and period P, `expire` is high in the cycle after the N·P-th rising edge following the write edge.
- R4: A read of address 2 returns the number of count steps not yet completed. It equals N from the write edge onward and drops by one at each step boundary, so the first drop shows after P edges.
- R5: Writes to address 2 are ignored and leave the current count unchanged. Reads of address 3 return zero.
- R6: When the count reaches zero, `expire` is high for exactly one cycle. The count then stays at zero until the next write to address 1.
- R7: Writing a starting count of zero leaves the timer stopped, with a current count of zero and no expiry pulse.
- R8: A change to the divide register while the timer runs does not affect the step in progress. The new period applies from the next step boundary onward.
- R9: A synchronous reset clears the divide register, the starting count and the current count, stops the timer, and holds `expire` low.
- R10: Writing a new starting count while the timer runs discards the old countdown and restarts timing from the new write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| wr_addr | input | 2 | Write address (0 divide, 1 start count, 2 current count) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Combinational read data |
| expire | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
A wrong prescaler phase or latched divide code does not show right away. It appears at the ports only as a current-count drop or an expiry pulse that comes early or late by a number of cycles, and that error can be as small as one edge. For this reason the bench measures the distance from the write edge to the expiry pulse exactly, for every divide code, and also samples the current count on both sides of the first step boundary. A stale count after a reload, or a count that keeps running after a zero write, shows up within one step period as a wrong readback or a missing or extra pulse.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    REG_DIV  = 2'd0,
    REG_INIT = 2'd1,
    REG_CUR  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // Pick the split code out of a divide-register write: bit 3 on top, bits 1:0 below.
  function automatic logic [CODE_W-1:0] code_of(input logic [31:0] d);
    return {d[3], d[1:0]};
  endfunction

  // Lay the code back out in the register's bit positions.
  function automatic logic [31:0] reg_of(input logic [CODE_W-1:0] c);
    return {28'd0, c[2], 1'b0, c[1:0]};
  endfunction
endpackage

// File: rtl/tmr_div_decode.sv
`timescale 1ns/1ps
module tmr_div_decode #(
  parameter int CODE_W = 3
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] shift_o
);
  // The rotated mapping: the shift is one more than the code, wrapping at the field width.
  always_comb shift_o = code_i + CODE_W'(1);
endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int CODE_W    = 3,
  parameter int PRE_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  input  logic              run_i,
  input  logic [CODE_W-1:0] shift_i,
  output logic              tick_o
);
  localparam int MAX_SHIFT = (1 << CODE_W) - 1;
  localparam int SUB_W     = PRE_SHIFT + MAX_SHIFT + 1;

  logic [SUB_W-1:0]  sub_q;
  logic [CODE_W-1:0] shift_q;
  logic [SUB_W-1:0]  last_v;

  always_comb begin
    last_v = (SUB_W'(1) << (SUB_W'(PRE_SHIFT) + SUB_W'(shift_q))) - SUB_W'(1);
    tick_o = run_i && (sub_q == last_v);
  end

  // The divide setting is sampled only on a restart or at a step boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q   <= '0;
      shift_q <= '0;
    end else if (restart_i || tick_o) begin
      sub_q   <= '0;
      shift_q <= shift_i;
    end else if (run_i) begin
      sub_q   <= sub_q + SUB_W'(1);
    end
  end

  assert_sub_in_window_R2: assert property (@(posedge clk) disable iff (rst)
    sub_q <= last_v);
  assert_phase_clears_R8: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (sub_q == '0));
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (load_i) begin
        cnt_q <= load_val_i;
      end else if (tick_i && cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) exp_q <= 1'b1;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign run_o    = (cnt_q != '0);
  assign expire_o = exp_q;

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> !expire_o);
  assert_hold_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
  assert_step_by_one_R4: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_W'(1)));
  assert_zero_load_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (load_i && load_val_i == '0) |=> !expire_o);
endmodule

// File: rtl/tick_countdown_timer.sv
`timescale 1ns/1ps
module tick_countdown_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int PRE_SHIFT = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        expire
);
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  init_q;
  logic [CODE_W-1:0] shift_w;
  logic [CNT_W-1:0]  cur_w;
  logic              run_w, tick_w, load_w;

  assign load_w = wr_en && (wr_addr == REG_INIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      init_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == REG_DIV)  code_q <= code_of(wr_data);
      if (wr_addr == REG_INIT) init_q <= CNT_W'(wr_data);
    end
  end

  tmr_div_decode #(.CODE_W(CODE_W)) u_decode (
    .code_i (code_q),
    .shift_o(shift_w)
  );

  tmr_prescaler #(.CODE_W(CODE_W), .PRE_SHIFT(PRE_SHIFT)) u_prescale (
    .clk      (clk),
    .rst      (rst),
    .restart_i(load_w),
    .run_i    (run_w),
    .shift_i  (shift_w),
    .tick_o   (tick_w)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load_w),
    .load_val_i(CNT_W'(wr_data)),
    .tick_i    (tick_w),
    .cnt_o     (cur_w),
    .run_o     (run_w),
    .expire_o  (expire)
  );

  always_comb begin
    case (reg_sel_e'(rd_addr))
      REG_DIV:  rd_data = reg_of(code_q);
      REG_INIT: rd_data = 32'(init_q);
      REG_CUR:  rd_data = 32'(cur_w);
      default:  rd_data = '0;
    endcase
  end

  assert_cur_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_CUR && !tick_w) |=> (cur_w == $past(cur_w)));
  assert_reset_quiet_R9: assert property (@(posedge clk)
    $past(rst) |-> (!expire && cur_w == '0));
endmodule

// File: tb/tick_countdown_timer_tb.sv
`timescale 1ns/1ps
module tick_countdown_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        expire;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  tick_countdown_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .expire(expire)
  );

  // {divide write data, start count, N*P}
  localparam logic [95:0] VEC [0:8] = '{
    {32'h0000000B, 32'd3, 32'd48},
    {32'h00000000, 32'd2, 32'd64},
    {32'h00000001, 32'd2, 32'd128},
    {32'h00000002, 32'd1, 32'd128},
    {32'h00000003, 32'd1, 32'd256},
    {32'h00000008, 32'd1, 32'd512},
    {32'h00000009, 32'd1, 32'd1024},
    {32'h0000000A, 32'd1, 32'd2048},
    {32'hFFFFFFF4, 32'd2, 32'd64}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge, returns at the following falling edge.
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // Counts falling edges since the write edge until expire; starts at 1.
  task automatic wait_expire(input int limit, output int k);
    k = 1;
    while (!expire && k < limit) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int k;
    bit seen;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    rd(2'd0, v); check("R9 div after reset", v, 0);
    rd(2'd1, v); check("R9 init after reset", v, 0);
    rd(2'd2, v); check("R9 cur after reset", v, 0);
    check("R9 expire after reset", 32'(expire), 0);
    @(negedge clk);

    // R2 R3 R1: all divide codes
    for (int i = 0; i < 9; i++) begin
      wr(2'd0, VEC[i][95:64]);
      rd(2'd0, v); check("R1 divide readback", v, VEC[i][95:64] & 32'hB);
      @(negedge clk);
      wr(2'd1, VEC[i][63:32]);
      wait_expire(5000, k);
      check("R2 R3 cycles to expiry", 32'(k), VEC[i][31:0] + 1);
      @(negedge clk);
      check("R6 pulse one cycle", 32'(expire), 0);
      rd(2'd2, v); check("R6 count held at zero", v, 0);
      rd(2'd1, v); check("R3 start count readback", v, VEC[i][63:32]);
      @(negedge clk);
    end

    // R1: wide write mask
    wr(2'd0, 32'hFFFFFFFF);
    rd(2'd0, v); check("R1 mask all ones", v, 32'hB);
    rd(2'd3, v); check("R5 unused address reads zero", v, 0);
    @(negedge clk);

    // R4 R5: step boundary and ignored current-count write
    wr(2'd1, 32'd5);
    rd(2'd2, v); check("R4 cur at load", v, 5);
    repeat (15) @(negedge clk);
    rd(2'd2, v); check("R4 cur before boundary", v, 5);
    @(negedge clk);
    rd(2'd2, v); check("R4 cur after boundary", v, 4);
    @(negedge clk);
    wr(2'd2, 32'h1234);
    rd(2'd2, v); check("R5 cur write ignored", v, 4);
    repeat (14) @(negedge clk);
    rd(2'd2, v); check("R4 second boundary", v, 3);
    wait_expire(200, k);
    @(negedge clk);

    // R8: divide change mid-step (period 16 then 32)
    wr(2'd1, 32'd3);
    repeat (4) @(negedge clk);
    wr(2'd0, 32'h0);
    k = 6;
    while (!expire && k < 500) begin @(negedge clk); k++; end
    check("R8 change applies at boundary", 32'(k), 81);
    @(negedge clk);

    // R10: reload while running (period 32 now; switch back to 16)
    wr(2'd0, 32'hB);
    wr(2'd1, 32'd10);
    repeat (19) @(negedge clk);
    check("R10 no early expiry", 32'(expire), 0);
    wr(2'd1, 32'd2);
    rd(2'd2, v); check("R10 reload value", v, 2);
    wait_expire(500, k);
    check("R10 restart timing", 32'(k), 33);
    @(negedge clk);

    // R7: zero start count
    wr(2'd1, 32'd0);
    rd(2'd2, v); check("R7 cur zero", v, 0);
    seen = 0;
    repeat (100) begin @(negedge clk); if (expire) seen = 1; end
    check("R7 no pulse", 32'(seen), 0);

    // R9: reset mid-run
    wr(2'd1, 32'd5);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(2'd0, v); check("R9 div cleared", v, 0);
    rd(2'd1, v); check("R9 init cleared", v, 0);
    rd(2'd2, v); check("R9 cur cleared", v, 0);
    seen = 0;
    repeat (200) begin @(negedge clk); if (expire) seen = 1; end
    check("R9 stopped after reset", 32'(seen), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule